// File: doc/BRIEF.md
# Sampling Phase Auto-Search Controller

This controller finds the best sampling clock phase for a front-end readout chip. When `start_i` is pulsed, it raises a trigger-inhibit output so that only idle synchronization pulses arrive, and then steps the phase-select output through every candidate phase in ascending order. After each phase change it drops a programmable number of settling samples. It then tracks the smallest and largest sample over a fixed window and scores the phase by the spread between them, maximum minus minimum.

When the last phase has been scored, the controller applies the phase with the largest spread. It also publishes a digital-level threshold for the downstream frame parser, placed midway between that phase's extremes. It then raises `done_o` and releases the trigger inhibit. `done_o` stays high until the next start. The phase-shifting clock generator sits outside this block.

Top module: `phase_search_ctrl`

## Requirements
- R1: After reset, `phase_sel_o` is 0, `trig_inhibit_o` is low, `done_o` is low and `thresh_o` is 0.
- R2: A start pulse accepted while idle or done sets `phase_sel_o` to 0, raises `trig_inhibit_o` and clears `done_o` on that same clock edge.
- R3: `trig_inhibit_o` stays high for the whole search and goes low on the edge where `done_o` rises.
- R4: Phases are tried in the order 0, 1, …, NUM_PHASES-1. Each phase is held on `phase_sel_o` for exactly SETTLE+WINDOW_LEN+1 cycles, where SETTLE is the value of `settle_i`.
- R5: After each phase is applied, the next SETTLE samples are discarded and the following WINDOW_LEN samples are measured. The one sample that follows the window, on the scoring cycle, is also ignored.
- R6: The phase with the largest max-minus-min spread is selected. When spreads are equal, the lower-numbered phase wins.
- R7: At completion, `thresh_o` becomes min + floor((max-min)/2) of the selected phase. It holds its previous value at all other times.
- R8: `done_o` rises together with the final `phase_sel_o` and stays high, with the phase and threshold held, until a new start pulse begins a new search.
- R9: A start pulse that arrives while a search is running has no effect on the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a search |
| settle_i | input | SETTLE_W | Number of samples to drop after each phase change |
| sample_i | input | SAMPLE_W | Digitized front-end sample |
| phase_sel_o | output | PHASE_W | Phase applied to the sampling clock generator |
| trig_inhibit_o | output | 1 | Holds triggers off while the search runs |
| thresh_o | output | SAMPLE_W | Digital-level threshold for the frame parser |
| done_o | output | 1 | Search finished; result valid |

## Verification
The hardest situation to reach from the ports is a settle or window count that is off by one. Any count error shifts which samples enter a window, yet the winning phase usually stays the same. To expose such errors, the bench drives a full-scale spike on every sample that must be discarded: the settling samples and the sample on the scoring cycle. A miscount therefore lets the spike into some phase's extremes, which changes that phase's spread and the final threshold. Two further cases are forced with crafted amplitudes: equal spreads on two phases, and a winner on the very last phase. A start pulse is also injected in the middle of one search.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_MEAS   = 3'd2,
    ST_EVAL   = 3'd3,
    ST_DONE   = 3'd4
  } phs_state_t;
endpackage

// File: rtl/phs_extrema_track.sv
module phs_extrema_track #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_i,
  input  logic                upd_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] min_o,
  output logic [SAMPLE_W-1:0] max_o
);
  logic [SAMPLE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (init_i) begin
      lo_q <= sample_i;
      hi_q <= sample_i;
    end else if (upd_i) begin
      if (sample_i < lo_q) lo_q <= sample_i;
      if (sample_i > hi_q) hi_q <= sample_i;
    end
  end

  assign min_o = lo_q;
  assign max_o = hi_q;

  // R5: the tracked extremes never cross once a window is open
  a_r5_extrema_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |-> (lo_q <= hi_q));
endmodule

// File: rtl/phs_best_keeper.sv
module phs_best_keeper #(
  parameter int SAMPLE_W = 12,
  parameter int PHASE_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                eval_i,
  input  logic [PHASE_W-1:0]  phase_i,
  input  logic [SAMPLE_W-1:0] min_i,
  input  logic [SAMPLE_W-1:0] max_i,
  output logic [PHASE_W-1:0]  win_phase_o,
  output logic [SAMPLE_W-1:0] win_min_o,
  output logic [SAMPLE_W-1:0] win_max_o,
  output logic                take_o
);
  function automatic logic [SAMPLE_W-1:0] span(input logic [SAMPLE_W-1:0] lo,
                                               input logic [SAMPLE_W-1:0] hi);
    return hi - lo;
  endfunction

  logic                have_q;
  logic [PHASE_W-1:0]  bph_q;
  logic [SAMPLE_W-1:0] bmin_q, bmax_q, brng_q;
  logic [SAMPLE_W-1:0] cur_rng;

  assign cur_rng = span(min_i, max_i);
  // strictly greater only: an equal spread keeps the earlier phase
  assign take_o  = eval_i && (!have_q || (cur_rng > brng_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      bph_q  <= '0;
      bmin_q <= '0;
      bmax_q <= '0;
      brng_q <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      brng_q <= '0;
    end else if (take_o) begin
      have_q <= 1'b1;
      bph_q  <= phase_i;
      bmin_q <= min_i;
      bmax_q <= max_i;
      brng_q <= cur_rng;
    end
  end

  assign win_phase_o = take_o ? phase_i : bph_q;
  assign win_min_o   = take_o ? min_i   : bmin_q;
  assign win_max_o   = take_o ? max_i   : bmax_q;

  // R6: the best spread held never shrinks within a search
  a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !clear_i) |=> (brng_q >= $past(brng_q)));
endmodule

// File: rtl/phs_seq_fsm.sv
module phs_seq_fsm
  import phs_pkg::*;
#(
  parameter int NUM_PHASES = 24,
  parameter int WINDOW_LEN = 1024,
  parameter int SETTLE_W   = 8,
  parameter int PHASE_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [PHASE_W-1:0]  cur_phase_o,
  output logic                clear_o,
  output logic                init_o,
  output logic                upd_o,
  output logic                eval_o,
  output logic                adv_o,
  output logic                fin_o,
  output logic                busy_o
);
  localparam int CW = $clog2(WINDOW_LEN + 1);
  localparam logic [CW-1:0]      LAST_W = CW'(WINDOW_LEN - 1);
  localparam logic [PHASE_W-1:0] LAST_P = PHASE_W'(NUM_PHASES - 1);

  phs_state_t          st_q, st_d;
  logic [SETTLE_W-1:0] scnt_q;
  logic [CW-1:0]       wcnt_q;
  logic [PHASE_W-1:0]  cur_q;
  logic                idle_like, settle_end, win_end;

  assign idle_like  = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign settle_end = (st_q == ST_SETTLE) && (scnt_q == settle_i);
  assign win_end    = (st_q == ST_MEAS) && (wcnt_q == LAST_W);

  assign clear_o = idle_like && start_i;
  assign init_o  = settle_end;
  assign upd_o   = (st_q == ST_MEAS);
  assign eval_o  = (st_q == ST_EVAL);
  assign fin_o   = eval_o && (cur_q == LAST_P);
  assign adv_o   = eval_o && (cur_q != LAST_P);
  assign busy_o  = !idle_like;

  always_comb begin
    st_d = st_q;
    if (clear_o)         st_d = ST_SETTLE;
    else if (settle_end) st_d = ST_MEAS;
    else if (win_end)    st_d = ST_EVAL;
    else if (fin_o)      st_d = ST_DONE;
    else if (adv_o)      st_d = ST_SETTLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      scnt_q <= '0;
      wcnt_q <= '0;
      cur_q  <= '0;
    end else begin
      st_q <= st_d;
      if (clear_o) begin
        cur_q  <= '0;
        scnt_q <= '0;
      end else if (adv_o) begin
        cur_q  <= cur_q + 1'b1;
        scnt_q <= '0;
      end else if ((st_q == ST_SETTLE) && !settle_end) begin
        scnt_q <= scnt_q + 1'b1;
      end
      if (settle_end)   wcnt_q <= CW'(1);
      else if (upd_o)   wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign cur_phase_o = cur_q;

  // R4: the phase index stays inside the candidate set
  a_r4_phase_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= LAST_P);
  // R5: the window counter never runs past the window length
  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (wcnt_q <= LAST_W));
  // R4: the phase index moves only on an advance or a new start
  a_r4_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_o && !clear_o) |=> $stable(cur_q));
endmodule

// File: rtl/phase_search_ctrl.sv
module phase_search_ctrl #(
  parameter int SAMPLE_W   = 12,
  parameter int NUM_PHASES = 24,
  parameter int WINDOW_LEN = 1024,
  parameter int SETTLE_W   = 8,
  parameter int PHASE_W    = $clog2(NUM_PHASES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [PHASE_W-1:0]  phase_sel_o,
  output logic                trig_inhibit_o,
  output logic [SAMPLE_W-1:0] thresh_o,
  output logic                done_o
);
  function automatic logic [SAMPLE_W-1:0] midpoint(input logic [SAMPLE_W-1:0] lo,
                                                   input logic [SAMPLE_W-1:0] hi);
    logic [SAMPLE_W-1:0] d;
    d = hi - lo;
    return lo + (d >> 1);
  endfunction

  logic [PHASE_W-1:0]  cur_phase, win_phase;
  logic [SAMPLE_W-1:0] trk_min, trk_max, win_min, win_max;
  logic clear_evt, init_evt, upd_evt, eval_evt, adv_evt, fin_evt, busy, take_evt;

  phs_seq_fsm #(
    .NUM_PHASES(NUM_PHASES), .WINDOW_LEN(WINDOW_LEN),
    .SETTLE_W(SETTLE_W), .PHASE_W(PHASE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
    .cur_phase_o(cur_phase), .clear_o(clear_evt), .init_o(init_evt),
    .upd_o(upd_evt), .eval_o(eval_evt), .adv_o(adv_evt), .fin_o(fin_evt),
    .busy_o(busy)
  );

  phs_extrema_track #(.SAMPLE_W(SAMPLE_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .init_i(init_evt), .upd_i(upd_evt),
    .sample_i(sample_i), .min_o(trk_min), .max_o(trk_max)
  );

  phs_best_keeper #(.SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_evt), .eval_i(eval_evt),
    .phase_i(cur_phase), .min_i(trk_min), .max_i(trk_max),
    .win_phase_o(win_phase), .win_min_o(win_min), .win_max_o(win_max),
    .take_o(take_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_sel_o    <= '0;
      trig_inhibit_o <= 1'b0;
      thresh_o       <= '0;
      done_o         <= 1'b0;
    end else if (clear_evt) begin
      phase_sel_o    <= '0;
      trig_inhibit_o <= 1'b1;
      done_o         <= 1'b0;
    end else if (adv_evt) begin
      phase_sel_o    <= cur_phase + 1'b1;
    end else if (fin_evt) begin
      phase_sel_o    <= win_phase;
      thresh_o       <= midpoint(win_min, win_max);
      trig_inhibit_o <= 1'b0;
      done_o         <= 1'b1;
    end
  end

  // R3: triggers are free once the result is valid
  a_r3_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !trig_inhibit_o);
  // R3: inhibit is held while a search runs past its first cycle
  a_r3_inhibit_in_search: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear_evt) |-> trig_inhibit_o);
  // R7: threshold lies within the selected phase's extremes
  a_r7_thresh_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !busy) |-> ((thresh_o >= win_min) && (thresh_o <= win_max)));
  // R8: done stays up until a new start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(phase_sel_o) && $stable(thresh_o)));
  // R9: start during a search leaves the phase alone
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !adv_evt && !fin_evt) |=> ($stable(phase_sel_o) && !done_o));
  // R6: selected phase is a legal candidate
  a_r6_pick_legal: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (cur_phase < PHASE_W'(NUM_PHASES)));
endmodule

// File: tb/sim_phase_search_ctrl.sv
`timescale 1ns/1ps
module sim_phase_search_ctrl;
  localparam int SW = 12;
  localparam int NP = 24;
  localparam int WL = 16;
  localparam int STW = 8;
  localparam int PW = 5;
  localparam int SPIKE = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [STW-1:0] settle_i = '0;
  logic [SW-1:0] sample_i = '0;
  logic [PW-1:0] phase_sel_o;
  logic trig_inhibit_o, done_o;
  logic [SW-1:0] thresh_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  int prev_thr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phase_search_ctrl #(.SAMPLE_W(SW), .NUM_PHASES(NP), .WINDOW_LEN(WL),
                      .SETTLE_W(STW), .PHASE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
    .sample_i(sample_i), .phase_sel_o(phase_sel_o), .trig_inhibit_o(trig_inhibit_o),
    .thresh_o(thresh_o), .done_o(done_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int amp_of(input int tst, input int p);
    case (tst)
      0: return (p == 13) ? 600 : 40 + 10 * p;
      1: return (p == 5 || p == 17) ? 500 : 100;
      2: return 100;
      default: return 50 + 3 * p;
    endcase
  endfunction

  function automatic int gen(input int tst, input int p, input int idx);
    int a, b;
    a = amp_of(tst, p);
    b = 1000 + 7 * p;
    if (idx == 3) return b + a;
    if (idx == 9) return b - a / 2;
    return b + idx % 3;
  endfunction

  task automatic compare(input int ph, input int inh, input int dn, input int thr, input string tag);
    chk(int'(phase_sel_o) == ph, {"R4 phase ", tag}, int'(phase_sel_o), ph);
    chk(int'(trig_inhibit_o) == inh, {"R3 inhibit ", tag}, int'(trig_inhibit_o), inh);
    chk(int'(done_o) == dn, {"R8 done ", tag}, int'(done_o), dn);
    chk(int'(thresh_o) == thr, {"R7 thresh ", tag}, int'(thresh_o), thr);
  endtask

  // behavioural reference: timeline by arithmetic, result by brute force
  task automatic run_search(input int tst, input int settle, input int glitch_at, input int exp_phase);
    int per, tot, bp, bmin, bmax, brng, thr;
    per = settle + WL + 1;
    tot = NP * per;
    bp = -1; bmin = 0; bmax = 0; brng = -1;
    for (int p = 0; p < NP; p++) begin
      int lo, hi;
      lo = 1 << 20; hi = -1;
      for (int i = 0; i < WL; i++) begin
        int v;
        v = gen(tst, p, i);
        if (v < lo) lo = v;
        if (v > hi) hi = v;
      end
      if (hi - lo > brng) begin brng = hi - lo; bp = p; bmin = lo; bmax = hi; end
    end
    thr = bmin + (bmax - bmin) / 2;
    chk(bp == exp_phase, "R6 model winner", bp, exp_phase);
    @(negedge clk);
    settle_i = STW'(settle);
    start_i = 1'b1;
    sample_i = SW'(SPIKE);
    @(posedge clk);
    for (int j = 0; j <= tot; j++) begin
      int m, p;
      @(negedge clk);
      start_i = 1'b0;
      if (j < tot) compare(j / per, 1, 0, prev_thr, "R2 R5 search");
      else compare(bp, 0, 1, thr, "R6 R7 final");
      m = j % per; p = j / per;
      if (j < tot && m >= settle && m < settle + WL) sample_i = SW'(gen(tst, p, m - settle));
      else sample_i = SW'(SPIKE);
      if (j == glitch_at) start_i = 1'b1;  // R9 start while busy
      if (j < tot) @(posedge clk);
    end
    prev_thr = thr;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sample_i = SW'(k * 333);
      compare(bp, 0, 1, thr, "R8 hold");
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    while (cyc < 100000 && !finished) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, 0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare(0, 0, 0, 0, "R1 after reset");
    run_search(0, 3, 50, 13);   // R6 clear winner, R9 start mid-search
    run_search(1, 0, -1, 5);    // R6 tie keeps lower phase, R5 zero settle
    run_search(2, 5, -1, 0);    // R6 all equal -> phase 0
    run_search(3, 2, 200, 23);  // R6 last phase wins, R9 again
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule